// File: doc/BRIEF.md
# FM Sound Generator Interval Timer Unit

This block provides the two interval timers of an FM sound generator, reached through a two-port indirect register scheme. A CPU writes a register index to the address port (`bus_a0` low), then writes values to the data port (`bus_a0` high). Every data write goes to whichever index was selected most recently. The selection is held until the next address-port write, so a data write always lands on the latest selected index. An interrupt handler that moves the selection between the main code's address write and its data write therefore sends that data write to the handler's register.

The control register drives both timers from one byte. Its bits set the run state of each timer, the interrupt enable of each timer, a one-shot reset of each overflow flag, and a two-bit mode field. The mode field is brought out as the channel-3 special mode pin and the composite sine mode pin. Timer A is a 10-bit up-counter with a fine prescale. Timer B is an 8-bit up-counter with a coarse prescale. On overflow, each timer sets its flag and reloads. A write to the key register is presented on a byte output, together with a one-cycle strobe.

Top module: `fm_timer_unit`

## Requirements
- R1: An address-port write stores `bus_wdata` as the selected index. Every later data-port write targets that index until the next address-port write, including when the index was changed by a nested access in between.
- R2: A data write to index 0x27 loads the control fields. Bit 0 runs timer A, bit 1 runs timer B, bit 2 enables the A interrupt and bit 3 enables the B interrupt. Bit 6 drives `mode_ch3` and bit 7 drives `mode_csm`.
- R3: Control bit 4 clears flag A and bit 5 clears flag B, visible in the cycle after the write. These two bits are not stored.
- R4: Timer A reloads from {index 0x24 value, index 0x25 bits 1:0}. After a write that turns its run bit from 0 to 1, its flag rises (1024 − reload) × PRE_A clock edges later, counting the write edge as edge zero.
- R5: Timer B reloads from the index 0x26 value. After its run bit turns from 0 to 1, its flag rises (256 − reload) × PRE_B edges later.
- R6: `irq` is high while a set flag has its interrupt enabled. A set flag without its enable leaves `irq` low.
- R7: `bus_rdata` bit 0 shows flag A and bit 1 shows flag B. Bits 7:2 read zero.
- R8: A data write to index 0x28 puts the value on `key_data` and raises `key_stb` for exactly the following cycle.
- R9: Data writes to any index other than 0x24 through 0x28 change no output.
- R10: A timer whose run bit is 0 never sets its flag.
- R11: With reload 0, each timer's period is 2^width × prescale cycles. This period is at most CLK_HZ/10, so neither timer can run slower than 10 Hz; elaboration fails otherwise.
- R12: After reset, all flags, modes, `irq`, `key_stb` and `key_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_a0 | input | 1 | 0 selects the address port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Status: flag B in bit 1, flag A in bit 0 |
| irq | output | 1 | Interrupt request |
| mode_ch3 | output | 1 | Channel-3 special mode |
| mode_csm | output | 1 | Composite sine mode |
| key_data | output | 8 | Last key-register value |
| key_stb | output | 1 | One-cycle pulse after a key write |

## Verification
Every register result appears one edge after the write that causes it: control fields, flag resets, `key_data` and `key_stb`. The bench samples these at the falling edge that follows the write edge. Flag and interrupt rises are due exactly (2^width − reload) × prescale edges after the starting write. The bench counts rising edges from that write and samples each count at the next falling edge, so the measured count must equal the computed period exactly. The strobe is checked again one cycle later to confirm it has fallen.

// File: rtl/fm_timer_pkg.sv
package fm_timer_pkg;

  localparam logic [7:0] IDX_TA_HI = 8'h24;
  localparam logic [7:0] IDX_TA_LO = 8'h25;
  localparam logic [7:0] IDX_TB    = 8'h26;
  localparam logic [7:0] IDX_CTRL  = 8'h27;
  localparam logic [7:0] IDX_KEY   = 8'h28;

  typedef struct packed {
    logic [1:0] mode;   // [7:6]
    logic       clr_b;  // [5]
    logic       clr_a;  // [4]
    logic       ien_b;  // [3]
    logic       ien_a;  // [2]
    logic       run_b;  // [1]
    logic       run_a;  // [0]
  } ctrl_t;

  // cycles from start edge to flag for a given counter width, reload, prescale
  function automatic longint ovf_period(int width, int reload, int pre);
    return ((longint'(1) << width) - longint'(reload)) * longint'(pre);
  endfunction

endpackage

// File: rtl/fm_reg_port.sv
module fm_reg_port
  import fm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       a0,
  input  logic [7:0] wdata,
  output logic [7:0] sel,
  output logic       wr_ta_hi,
  output logic       wr_ta_lo,
  output logic       wr_tb,
  output logic       wr_ctrl,
  output logic       wr_key
);

  logic [7:0] sel_q;
  logic       dwr;

  always_ff @(posedge clk) begin
    if (!rst_n)          sel_q <= '0;
    else if (we && !a0)  sel_q <= wdata;
  end

  assign sel      = sel_q;
  assign dwr      = we && a0;
  assign wr_ta_hi = dwr && (sel_q == IDX_TA_HI);
  assign wr_ta_lo = dwr && (sel_q == IDX_TA_LO);
  assign wr_tb    = dwr && (sel_q == IDX_TB);
  assign wr_ctrl  = dwr && (sel_q == IDX_CTRL);
  assign wr_key   = dwr && (sel_q == IDX_KEY);

endmodule

// File: rtl/fm_interval_timer.sv
module fm_interval_timer #(
  parameter int W   = 10,
  parameter int PRE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         ovf
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic         tick;
  logic [W-1:0] cnt_q;

  generate
    if (PRE > 1) begin : g_pre
      localparam int PW = $clog2(PRE);
      localparam logic [PW-1:0] PRE_LAST = PW'(PRE - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     pre_q <= '0;
        else if (start) pre_q <= '0;
        else if (run)   pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      end
      assign tick = run && !start && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign tick = run && !start;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= reload;
    else if (tick)  cnt_q <= (cnt_q == CNT_MAX) ? reload : cnt_q + 1'b1;
  end

  assign ovf = tick && (cnt_q == CNT_MAX);

endmodule

// File: rtl/fm_timer_unit.sv
module fm_timer_unit
  import fm_timer_pkg::*;
#(
  parameter longint CLK_HZ = 100_000_000,
  parameter int     WA     = 10,
  parameter int     WB     = 8,
  parameter int     PRE_A  = 4,
  parameter int     PRE_B  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_a0,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       mode_ch3,
  output logic       mode_csm,
  output logic [7:0] key_data,
  output logic       key_stb
);

  localparam longint SLOW_A   = ovf_period(WA, 0, PRE_A);
  localparam longint SLOW_B   = ovf_period(WB, 0, PRE_B);
  localparam longint SLOW_LIM = CLK_HZ / 10;
  localparam int     LOW_W    = WA - 8;

  generate
    if (SLOW_A > SLOW_LIM || SLOW_B > SLOW_LIM) begin : g_rate_bad
      $error("timer prescale allows periods longer than a tenth of a second");
    end
  endgenerate

  logic [7:0] sel_idx;
  logic       wr_ta_hi, wr_ta_lo, wr_tb, wr_ctrl, wr_key;
  ctrl_t      wctl;

  fm_reg_port u_port (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .a0(bus_a0), .wdata(bus_wdata),
    .sel(sel_idx), .wr_ta_hi(wr_ta_hi), .wr_ta_lo(wr_ta_lo), .wr_tb(wr_tb),
    .wr_ctrl(wr_ctrl), .wr_key(wr_key)
  );

  assign wctl = ctrl_t'(bus_wdata);

  logic [7:0]       ta_hi_q;
  logic [LOW_W-1:0] ta_lo_q;
  logic [WB-1:0]    tb_q;
  logic             run_a, run_b, en_a, en_b;
  logic [1:0]       mode_q;
  logic             flag_a, flag_b;
  logic [7:0]       key_q;
  logic             stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta_hi_q <= '0;
      ta_lo_q <= '0;
      tb_q    <= '0;
      run_a   <= 1'b0;
      run_b   <= 1'b0;
      en_a    <= 1'b0;
      en_b    <= 1'b0;
      mode_q  <= '0;
      key_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= wr_key;
      if (wr_ta_hi) ta_hi_q <= bus_wdata;
      if (wr_ta_lo) ta_lo_q <= bus_wdata[LOW_W-1:0];
      if (wr_tb)    tb_q    <= bus_wdata[WB-1:0];
      if (wr_key)   key_q   <= bus_wdata;
      if (wr_ctrl) begin
        run_a  <= wctl.run_a;
        run_b  <= wctl.run_b;
        en_a   <= wctl.ien_a;
        en_b   <= wctl.ien_b;
        mode_q <= wctl.mode;
      end
    end
  end

  logic start_a, start_b, ovf_a, ovf_b, clr_a, clr_b;

  assign start_a = wr_ctrl && wctl.run_a && !run_a;
  assign start_b = wr_ctrl && wctl.run_b && !run_b;
  assign clr_a   = wr_ctrl && wctl.clr_a;
  assign clr_b   = wr_ctrl && wctl.clr_b;

  fm_interval_timer #(.W(WA), .PRE(PRE_A)) u_tmr_a (
    .clk(clk), .rst_n(rst_n), .start(start_a), .run(run_a),
    .reload({ta_hi_q, ta_lo_q}), .ovf(ovf_a)
  );

  fm_interval_timer #(.W(WB), .PRE(PRE_B)) u_tmr_b (
    .clk(clk), .rst_n(rst_n), .start(start_b), .run(run_b),
    .reload(tb_q), .ovf(ovf_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      if (clr_a)      flag_a <= 1'b0;
      else if (ovf_a) flag_a <= 1'b1;
      if (clr_b)      flag_b <= 1'b0;
      else if (ovf_b) flag_b <= 1'b1;
    end
  end

  assign bus_rdata = {6'b0, flag_b, flag_a};
  assign irq       = (flag_a && en_a) || (flag_b && en_b);
  assign mode_ch3  = mode_q[0];
  assign mode_csm  = mode_q[1];
  assign key_data  = key_q;
  assign key_stb   = stb_q;

endmodule

// File: rtl/fm_timer_unit_chk.sv
module fm_timer_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic       bus_a0,
  input logic [7:0] bus_wdata,
  input logic [7:0] sel_idx,
  input logic       ovf_a,
  input logic       ovf_b,
  input logic [7:0] bus_rdata,
  input logic       irq,
  input logic       mode_ch3,
  input logic       mode_csm,
  input logic [7:0] key_data,
  input logic       key_stb
);

  // R1: selection only moves on an address-port write
  a_r1_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && !bus_a0) |=> $stable(sel_idx));

  // R2: control write sets the mode pins
  a_r2_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_a0 && sel_idx == 8'h27) |=> ({mode_csm, mode_ch3} == $past(bus_wdata[7:6])));

  // R3: flag reset bit clears flag A
  a_r3_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_a0 && sel_idx == 8'h27 && bus_wdata[4]) |=> !bus_rdata[0]);

  // R4: flag A only rises after a timer A overflow
  a_r4_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[0]) |-> $past(ovf_a));

  // R5: flag B only rises after a timer B overflow
  a_r5_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[1]) |-> $past(ovf_b));

  // R6: interrupt needs a set flag
  a_r6_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (bus_rdata[1:0] != 2'b00));

  // R7: upper status bits stay zero
  a_r7_status_hi: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:2] == 6'b0);

  // R8: key write produces strobe and data
  a_r8_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_a0 && sel_idx == 8'h28) |=> (key_stb && key_data == $past(bus_wdata)));

endmodule

bind fm_timer_unit fm_timer_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_a0(bus_a0), .bus_wdata(bus_wdata),
  .sel_idx(sel_idx), .ovf_a(ovf_a), .ovf_b(ovf_b), .bus_rdata(bus_rdata), .irq(irq),
  .mode_ch3(mode_ch3), .mode_csm(mode_csm), .key_data(key_data), .key_stb(key_stb)
);

// File: tb/fm_timer_unit_tb.sv
module fm_timer_unit_tb;

  localparam longint CLK_HZ = 100_000_000;
  localparam int PRE_A = 4;
  localparam int PRE_B = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_a0 = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, mode_ch3, mode_csm, key_stb;
  logic [7:0] key_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fm_timer_unit #(.CLK_HZ(CLK_HZ), .PRE_A(PRE_A), .PRE_B(PRE_B)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_a0(bus_a0), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .mode_ch3(mode_ch3), .mode_csm(mode_csm),
    .key_data(key_data), .key_stb(key_stb)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_wr(input bit a0, input logic [7:0] v);
    bus_we = 1'b1; bus_a0 = a0; bus_wdata = v;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_a0 = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] v);
    bus_wr(1'b0, idx);
    bus_wr(1'b1, v);
  endtask

  // edges from the last write edge until status bit b is seen set
  task automatic measure(input int b, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!bus_rdata[b] && n < 20000);
  endtask

  function automatic int period(int w, int r, int pre);
    return ((1 << w) - r) * pre;
  endfunction

  task automatic t_reset();
    check(bus_rdata == 8'h00, "R12 status", bus_rdata, 0);
    check(!irq && !key_stb, "R12 irq/stb", {irq, key_stb}, 0);
    check(!mode_ch3 && !mode_csm && key_data == 0, "R12 modes/key", {mode_csm, mode_ch3, key_data}, 0);
  endtask

  task automatic t_modes();
    wreg(8'h27, 8'hC0);
    check(mode_ch3 && mode_csm, "R2 modes set", {mode_csm, mode_ch3}, 3);
    check(bus_rdata == 0 && !irq, "R2 timers idle", bus_rdata, 0);
    wreg(8'h27, 8'h40);
    check(mode_ch3 && !mode_csm, "R2 ch3 only", {mode_csm, mode_ch3}, 1);
    wreg(8'h27, 8'h00);
  endtask

  task automatic t_timer_a();
    int n;
    wreg(8'h24, 8'hF0);
    wreg(8'h25, 8'h02);          // reload = 0x3C2 = 962
    wreg(8'h27, 8'h35);
    measure(0, n);
    check(n == period(10, 962, PRE_A), "R4 timer A period", n, period(10, 962, PRE_A));
    check(irq, "R6 irq with enable A", irq, 1);
    check(bus_rdata == 8'h01, "R7 status A", bus_rdata, 1);
    wreg(8'h27, 8'h35);           // run already set: only clears flags
    check(bus_rdata[0] == 0 && !irq, "R3 clear A", bus_rdata, 0);
  endtask

  task automatic t_timer_b();
    int n;
    wreg(8'h27, 8'h30);           // stop A, clear flags
    wreg(8'h26, 8'hFC);
    wreg(8'h27, 8'h02);           // run B, no enable
    measure(1, n);
    check(n == period(8, 252, PRE_B), "R5 timer B period", n, period(8, 252, PRE_B));
    check(!irq, "R6 no irq without enable", irq, 0);
    check(bus_rdata == 8'h02, "R7 status B", bus_rdata, 2);
    wreg(8'h27, 8'h08);           // stop B, enable B irq, flag kept
    check(irq, "R6 irq after enable B", irq, 1);
    wreg(8'h27, 8'h20);
    check(bus_rdata == 0 && !irq, "R3 clear B", bus_rdata, 0);
  endtask

  task automatic t_stopped();
    repeat (6000) @(negedge clk);
    check(bus_rdata == 0, "R10 stopped timers", bus_rdata, 0);
  endtask

  task automatic t_slowest();
    int n;
    wreg(8'h24, 8'h00);
    wreg(8'h25, 8'h00);
    wreg(8'h27, 8'h01);
    measure(0, n);
    check(n == 1024 * PRE_A, "R11 slowest A", n, 1024 * PRE_A);
    check(n <= CLK_HZ / 10, "R11 10 Hz bound", n, CLK_HZ / 10);
    wreg(8'h27, 8'h30);
  endtask

  task automatic t_key();
    wreg(8'h28, 8'h5A);
    check(key_stb && key_data == 8'h5A, "R8 key write", {key_stb, key_data}, 9'h15A);
    @(negedge clk);
    check(!key_stb, "R8 strobe one cycle", key_stb, 0);
  endtask

  task automatic t_unknown();
    wreg(8'h29, 8'hFF);
    check(!key_stb && key_data == 8'h5A, "R9 key untouched", {key_stb, key_data}, 8'h5A);
    wreg(8'h10, 8'hFF);
    check(!mode_ch3 && !mode_csm && bus_rdata == 0 && !irq, "R9 no effect",
          {mode_csm, mode_ch3, bus_rdata}, 0);
  endtask

  task automatic t_clobber();
    bus_wr(1'b0, 8'h28);          // main code selects key register
    bus_wr(1'b0, 8'h27);          // handler selects control
    bus_wr(1'b1, 8'h30);          // handler clears flags
    bus_wr(1'b1, 8'hC0);          // main code data write
    check(!key_stb && key_data == 8'h5A, "R1 key not written", {key_stb, key_data}, 8'h5A);
    check(mode_ch3 && mode_csm, "R1 write landed in control", {mode_csm, mode_ch3}, 3);
    bus_wr(1'b1, 8'h00);          // latch still selects control
    check(!mode_ch3 && !mode_csm, "R1 selection persists", {mode_csm, mode_ch3}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_timer_a();
    t_timer_b();
    t_stopped();
    t_slowest();
    t_key();
    t_unknown();
    t_clobber();
    summary();
  end

endmodule